// File: doc/BRIEF.md
# Input Enable Sample Gating Front End

This block sits at the head of one receive channel. Two wideband input ports each carry a 14-bit two's-complement mantissa, a 3-bit unsigned exponent and an enable line. The channel picks one port and reads its enable line in one of four gating modes. The mode decides three things: on which clocks a new sample is taken, on which clocks the oscillator phase may step, and when the data is forced to zero. The block also routes one of four synchronisation pins into the channel.

It has three outputs. The first is a registered sample together with a one-cycle valid pulse. The second is an oscillator-advance strobe. The third is a back-end clock enable, which keeps the filter chain computing on every clock whether or not a new sample arrived. Each output is registered once, so it reflects the inputs sampled at the previous rising clock edge.

Top module: `smp_gate_front`

## Requirements
- R1: With cfg_gate_mode = 2'b00 (blank mode), a sample is produced on every clock. It equals the selected port's mantissa and exponent while the selected enable is high, and is all zeros while it is low. smp_vld and nco_step are high on every clock.
- R2: With cfg_gate_mode = 2'b01 (level mode), a sample is taken on every clock where the selected enable is high. On clocks where it is low, smp_vld and nco_step are low and the sample output keeps its previous value.
- R3: With cfg_gate_mode = 2'b10 (rising mode), a sample is taken only on a clock where the selected enable is high and was low at the previous clock. After reset the previous value counts as low.
- R4: With cfg_gate_mode = 2'b11 (falling mode), a sample is taken only on a clock where the selected enable is low and was high at the previous clock.
- R5: In modes 01, 10 and 11, nco_step pulses on exactly the clocks where smp_vld pulses. On all other clocks smp_man and smp_exp hold the last value that was taken.
- R6: be_ce is high on every clock after reset, in every mode, whatever the enable line does.
- R7: cfg_src_b = 1 selects port B and cfg_src_b = 0 selects port A. The choice switches the mantissa, the exponent and the enable line together.
- R8: sync_out equals sync_pins[cfg_sync_sel], one clock later. Value 0 selects pin A, 1 selects B, 2 selects C and 3 selects D.
- R9: While rst_n is low, every output is zero and the stored previous enable is low.
- R10: Each output reflects the inputs sampled at the previous rising clock edge, with exactly one register stage of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_gate_mode | input | 2 | Gating mode: 00 blank, 01 level, 10 rising, 11 falling |
| cfg_src_b | input | 1 | 1 selects port B, 0 selects port A |
| cfg_sync_sel | input | 2 | Sync pin select |
| a_man | input | 14 | Port A mantissa, two's complement |
| a_exp | input | 3 | Port A exponent, unsigned |
| a_en | input | 1 | Port A enable |
| b_man | input | 14 | Port B mantissa, two's complement |
| b_exp | input | 3 | Port B exponent, unsigned |
| b_en | input | 1 | Port B enable |
| sync_pins | input | 4 | Sync pins A to D (bits 0 to 3) |
| smp_man | output | 14 | Gated sample mantissa |
| smp_exp | output | 3 | Gated sample exponent |
| smp_vld | output | 1 | New-sample pulse |
| nco_step | output | 1 | Oscillator advance strobe |
| be_ce | output | 1 | Back-end clock enable |
| sync_out | output | 1 | Selected sync pin |

## Verification
Every result of this block is due exactly one clock after the inputs that produce it. The bench therefore drives each stimulus on the falling edge and reads the outputs just after the next rising edge. At that point it compares them with a model that advanced one step on the same stimulus. Edge modes depend on the enable value from the previous clock, so the model keeps its own copy of the previous enable of the selected port. A port switch makes that copy refer to the new port's line on the next clock, and the model follows this.

// File: rtl/sgf_pkg.sv
package sgf_pkg;
    typedef enum logic [1:0] {
        GATE_BLANK = 2'b00,
        GATE_LEVEL = 2'b01,
        GATE_RISE  = 2'b10,
        GATE_FALL  = 2'b11
    } gate_mode_e;
endpackage

// File: rtl/sgf_port_sel.sv
module sgf_port_sel #(
    parameter int MAN_W = 14,
    parameter int EXP_W = 3
) (
    input  logic             src_b,
    input  logic [MAN_W-1:0] a_man,
    input  logic [EXP_W-1:0] a_exp,
    input  logic             a_en,
    input  logic [MAN_W-1:0] b_man,
    input  logic [EXP_W-1:0] b_exp,
    input  logic             b_en,
    output logic [MAN_W-1:0] sel_man,
    output logic [EXP_W-1:0] sel_exp,
    output logic             sel_en
);
    // mantissa, exponent and enable always switch as one group (R7)
    always_comb begin
        if (src_b) begin
            sel_man = b_man;
            sel_exp = b_exp;
            sel_en  = b_en;
        end else begin
            sel_man = a_man;
            sel_exp = a_exp;
            sel_en  = a_en;
        end
    end
endmodule

// File: rtl/sgf_gate_ctl.sv
module sgf_gate_ctl
    import sgf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  gate_mode_e mode,
    input  logic       en,
    output logic       take,
    output logic       blank
);
    logic en_prev_d, en_prev_q;

    always_comb begin
        en_prev_d = en;
        blank     = (mode == GATE_BLANK) && !en;
        unique case (mode)
            GATE_BLANK: take = 1'b1;
            GATE_LEVEL: take = en;
            GATE_RISE:  take = en && !en_prev_q;
            GATE_FALL:  take = !en && en_prev_q;
            default:    take = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_prev_q <= 1'b0;
        else        en_prev_q <= en_prev_d;
    end

    // an edge mode never takes two samples in a row while the mode is unchanged (R3, R4)
    p_no_back2back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == GATE_RISE || mode == GATE_FALL) && take) |=> !(take && $stable(mode)));
endmodule

// File: rtl/sgf_sync_sel.sv
module sgf_sync_sel #(
    parameter int NUM_SYNC = 4,
    localparam int SEL_W = (NUM_SYNC > 1) ? $clog2(NUM_SYNC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    sel,
    input  logic [NUM_SYNC-1:0] pins,
    output logic                sync_q
);
    logic sync_d;

    always_comb begin
        sync_d = 1'b0;
        for (int i = 0; i < NUM_SYNC; i++) begin
            if (sel == SEL_W'(i)) sync_d = pins[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_d;
    end

    p_sync_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sync_q == $past(pins[sel])));
endmodule

// File: rtl/smp_gate_front.sv
module smp_gate_front
    import sgf_pkg::*;
#(
    parameter int MAN_W    = 14,
    parameter int EXP_W    = 3,
    parameter int NUM_SYNC = 4,
    localparam int SEL_W   = (NUM_SYNC > 1) ? $clog2(NUM_SYNC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_gate_mode,
    input  logic                cfg_src_b,
    input  logic [SEL_W-1:0]    cfg_sync_sel,
    input  logic [MAN_W-1:0]    a_man,
    input  logic [EXP_W-1:0]    a_exp,
    input  logic                a_en,
    input  logic [MAN_W-1:0]    b_man,
    input  logic [EXP_W-1:0]    b_exp,
    input  logic                b_en,
    input  logic [NUM_SYNC-1:0] sync_pins,
    output logic [MAN_W-1:0]    smp_man,
    output logic [EXP_W-1:0]    smp_exp,
    output logic                smp_vld,
    output logic                nco_step,
    output logic                be_ce,
    output logic                sync_out
);
    typedef struct packed {
        logic [MAN_W-1:0] man;
        logic [EXP_W-1:0] expo;
        logic             vld;
        logic             step;
        logic             ce;
    } front_t;

    logic [MAN_W-1:0] sel_man;
    logic [EXP_W-1:0] sel_exp;
    logic             sel_en;
    logic             take, blank;
    gate_mode_e       mode;
    front_t           st_d, st_q;

    assign mode = gate_mode_e'(cfg_gate_mode);

    sgf_port_sel #(.MAN_W(MAN_W), .EXP_W(EXP_W)) u_port (
        .src_b(cfg_src_b),
        .a_man(a_man), .a_exp(a_exp), .a_en(a_en),
        .b_man(b_man), .b_exp(b_exp), .b_en(b_en),
        .sel_man(sel_man), .sel_exp(sel_exp), .sel_en(sel_en)
    );

    sgf_gate_ctl u_gate (
        .clk(clk), .rst_n(rst_n), .mode(mode), .en(sel_en),
        .take(take), .blank(blank)
    );

    sgf_sync_sel #(.NUM_SYNC(NUM_SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .sel(cfg_sync_sel), .pins(sync_pins),
        .sync_q(sync_out)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.step = 1'b0;
        st_d.ce   = 1'b1;
        if (take) begin
            st_d.vld  = 1'b1;
            st_d.step = 1'b1;
            st_d.man  = blank ? '0 : sel_man;
            st_d.expo = blank ? '0 : sel_exp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_man  = st_q.man;
    assign smp_exp  = st_q.expo;
    assign smp_vld  = st_q.vld;
    assign nco_step = st_q.step;
    assign be_ce    = st_q.ce;

    p_blank_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == GATE_BLANK && !$past(sel_en))
        |-> (smp_man == '0 && smp_exp == '0 && smp_vld));

    p_step_with_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nco_step == smp_vld);

    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !smp_vld) |-> ($stable(smp_man) && $stable(smp_exp)));

    p_level_low_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == GATE_LEVEL && !$past(sel_en)) |-> !smp_vld);

    p_backend_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> be_ce);
endmodule

// File: tb/smp_gate_front_test.sv
`timescale 1ns/1ps
module smp_gate_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_gate_mode = 2'b00;
    logic        cfg_src_b = 1'b0;
    logic [1:0]  cfg_sync_sel = 2'b00;
    logic [13:0] a_man = '0, b_man = '0;
    logic [2:0]  a_exp = '0, b_exp = '0;
    logic        a_en = 1'b0, b_en = 1'b0;
    logic [3:0]  sync_pins = '0;
    logic [13:0] smp_man;
    logic [2:0]  smp_exp;
    logic        smp_vld, nco_step, be_ce, sync_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench model state
    logic [13:0] m_man;
    logic [2:0]  m_exp;
    logic        m_vld, m_prev;

    always #2.5 clk = ~clk;

    smp_gate_front uut (
        .clk(clk), .rst_n(rst_n), .cfg_gate_mode(cfg_gate_mode),
        .cfg_src_b(cfg_src_b), .cfg_sync_sel(cfg_sync_sel),
        .a_man(a_man), .a_exp(a_exp), .a_en(a_en),
        .b_man(b_man), .b_exp(b_exp), .b_en(b_en),
        .sync_pins(sync_pins),
        .smp_man(smp_man), .smp_exp(smp_exp), .smp_vld(smp_vld),
        .nco_step(nco_step), .be_ce(be_ce), .sync_out(sync_out)
    );

    task automatic chk(input string tag, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic logic take_f(input logic [1:0] md, input logic en, input logic prev);
        case (md)
            2'b00:   return 1'b1;
            2'b01:   return en;
            2'b10:   return en && !prev;
            default: return !en && prev;
        endcase
    endfunction

    function automatic string tag_f(input logic [1:0] md);
        case (md)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    // one clock: inputs already driven; advance model, then compare after edge (R10)
    task automatic cycle();
        logic        en;
        logic [13:0] man;
        logic [2:0]  ex;
        logic        tk, sy;
        string       t;
        en  = cfg_src_b ? b_en  : a_en;
        man = cfg_src_b ? b_man : a_man;
        ex  = cfg_src_b ? b_exp : a_exp;
        tk  = take_f(cfg_gate_mode, en, m_prev);
        sy  = sync_pins[cfg_sync_sel];
        t   = tag_f(cfg_gate_mode);
        m_vld = tk;
        if (tk) begin
            m_man = (cfg_gate_mode == 2'b00 && !en) ? 14'd0 : man;
            m_exp = (cfg_gate_mode == 2'b00 && !en) ? 3'd0  : ex;
        end
        m_prev = en;
        @(posedge clk);
        #0.5;
        chk({t, cfg_src_b ? "/R7 man" : " man"}, int'(smp_man), int'(m_man));
        chk({t, cfg_src_b ? "/R7 exp" : " exp"}, int'(smp_exp), int'(m_exp));
        chk({t, " vld"}, int'(smp_vld), int'(m_vld));
        chk("R5 step", int'(nco_step), int'(m_vld));
        chk("R6 be_ce", int'(be_ce), 1);
        chk("R8 sync", int'(sync_out), int'(sy));
        @(negedge clk);
    endtask

    task automatic rand_inputs(input int en_bias);
        a_man = 14'($urandom); b_man = 14'($urandom);
        a_exp = 3'($urandom);  b_exp = 3'($urandom);
        a_en  = ($urandom_range(0, 99) < en_bias);
        b_en  = ($urandom_range(0, 99) < en_bias);
        sync_pins    = 4'($urandom);
        cfg_sync_sel = 2'($urandom);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_man = '0; m_exp = '0; m_vld = 1'b0; m_prev = 1'b0;
        a_man = 14'h1abc; a_en = 1'b1; sync_pins = 4'hf;
        repeat (3) @(negedge clk);
        // R9: outputs zero while in reset despite active inputs
        chk("R9 man", int'(smp_man), 0);
        chk("R9 vld", int'(smp_vld), 0);
        chk("R9 step", int'(nco_step), 0);
        chk("R9 be_ce", int'(be_ce), 0);
        chk("R9 sync", int'(sync_out), 0);
        // R3: rising mode, enable already high on first clock after reset: prev counts low
        cfg_gate_mode = 2'b10;
        rst_n = 1'b1;
        cycle();
        // held high: no second sample (R3)
        a_man = 14'h0123;
        cycle();
        // R1 directed: blank mode with enable low gives zeros; negative mantissa passes when high
        cfg_gate_mode = 2'b00;
        a_en = 1'b0; a_man = 14'h2000; a_exp = 3'd7;
        cycle();
        a_en = 1'b1;
        cycle();
        // R4 directed: falling edge
        cfg_gate_mode = 2'b11;
        a_en = 1'b1; cycle();
        a_en = 1'b0; a_man = 14'h3fff; cycle();
        a_en = 1'b0; cycle();
        // R7 directed: switch to B, enable follows port
        cfg_src_b = 1'b1; cfg_gate_mode = 2'b01;
        a_en = 1'b1; b_en = 1'b0; cycle();
        a_en = 1'b0; b_en = 1'b1; b_man = 14'h0555; b_exp = 3'd5; cycle();
        // R8 directed: each select value
        for (int s = 0; s < 4; s++) begin
            cfg_sync_sel = 2'(s);
            sync_pins = 4'(1 << s);
            cycle();
        end
        // random phase across modes and ports
        for (int md = 0; md < 4; md++) begin
            for (int p = 0; p < 2; p++) begin
                cfg_gate_mode = 2'(md);
                cfg_src_b = p[0];
                for (int k = 0; k < 300; k++) begin
                    rand_inputs((k < 150) ? 50 : 85);
                    if ($urandom_range(0, 49) == 0) cfg_src_b = ~cfg_src_b;
                    cycle();
                end
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule